// File: doc/BRIEF.md
# Link-On Wake Signal Generator

This block tells a powered-down link-layer controller to come back up. It watches two things: whether the link side reports itself powered, and whether a software-owned link-control bit is set. When the link counts as asleep and a wake event arrives, the block raises a request. A wake event is either a link-on packet addressed to this node or an enabled PHY interrupt. While the request stands, the block drives a square wave on its single output. A clock divider inside the block makes that wave.

The request ends when the link becomes active. A bus reset also ends it, unless an enabled PHY interrupt is still pending. After power-up, a separate timed window can hold the output active for a fixed number of cycles. This happens only for low power classes. The window ends early if the link comes up. The block needs no configuration beyond its parameters. It connects directly to the packet decoder, the interrupt logic and the power monitor.

Top module: `linkon_wake_gen`

## Requirements
- R1: The link is active only when `link_status` is 1 and `link_ctrl` is 1. A `linkon_pkt` or enabled interrupt that arrives while the link is active leaves `link_on` low.
- R2: A one-cycle `linkon_pkt` sampled while the link is inactive starts the output. This holds whether `link_status` is 0, `link_ctrl` is 0, or both.
- R3: `phy_int` counts as a wake event only while `phy_int_en` is 1. With `phy_int_en` at 0, the interrupt produces no output.
- R4: Once started, the output keeps running with no further events. It stops when the link becomes active: `link_on` is low from the second clock edge after the edge where the link is first sampled active, and it stays low.
- R5: A `bus_reset` pulse stops a running output unless `phy_int` and `phy_int_en` are both 1 in that cycle. If a wake event is sampled in the same cycle as `bus_reset`, the wake event wins.
- R6: A `pwr_on` pulse sampled while the link is inactive and `pwr_class` is 0 to 4 makes the block active for exactly `PWRUP_CYCLES` cycles. Classes 5 to 7 give no activity. The window ends early when the link becomes active.
- R7: While the block is active, `link_on` is a square wave. It goes high one edge after activation, then alternates between `DIV_HALF` cycles high and `DIV_HALF` cycles low. `link_on` is held low one edge after the block stops being active.
- R8: While `rst_n` is 0, `link_on` is 0 and all pending requests and windows are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_status | input | 1 | Link-side power status, 1 = powered |
| link_ctrl | input | 1 | Link-control register bit, 1 = link enabled |
| linkon_pkt | input | 1 | One-cycle pulse: link-on packet for this node received |
| phy_int | input | 1 | PHY interrupt condition pending (level) |
| phy_int_en | input | 1 | Allows `phy_int` to act as a wake event |
| bus_reset | input | 1 | One-cycle pulse on bus reset |
| pwr_class | input | 3 | Power class of the node, 0 to 7 |
| pwr_on | input | 1 | One-cycle pulse after a power cycle |
| link_on | output | 1 | Wake output, square wave while active |

## Verification
The bench builds the block with `DIV_HALF` = 3 and `PWRUP_CYCLES` = 20. With these values, a full high/low period and the whole power-up window each fit in a few tens of cycles. This makes it practical to count output-high cycles exactly across the window and to see its precise end. It also lets the same short observation span detect a running output after each combination of link state, wake event and bus reset.

// File: rtl/linkon_wake_gen.sv
module linkon_wake_gen #(
  parameter int DIV_HALF      = 16,
  parameter int PWRUP_CYCLES  = 41750,
  parameter int MAX_PWR_CLASS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_status,
  input  logic       link_ctrl,
  input  logic       linkon_pkt,
  input  logic       phy_int,
  input  logic       phy_int_en,
  input  logic       bus_reset,
  input  logic [2:0] pwr_class,
  input  logic       pwr_on,
  output logic       link_on
);

  localparam int DW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);
  localparam logic [PW-1:0] PU_LOAD  = PW'(PWRUP_CYCLES);

  logic          req_q;
  logic          run_q;
  logic [PW-1:0] pu_cnt;
  logic [DW-1:0] div_cnt;

  wire link_active = link_status & link_ctrl;
  wire int_hold    = phy_int & phy_int_en;
  wire wake        = linkon_pkt | int_hold;
  wire class_ok    = pwr_class <= 3'(MAX_PWR_CLASS);
  wire win         = pu_cnt != '0;
  wire act         = req_q | win;

  always_ff @(posedge clk) begin
    if (!rst_n)                     req_q <= 1'b0;
    else if (link_active)           req_q <= 1'b0;
    else if (wake)                  req_q <= 1'b1;
    else if (bus_reset && !int_hold) req_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pu_cnt <= '0;
    else if (link_active)         pu_cnt <= '0;
    else if (pwr_on && class_ok)  pu_cnt <= PU_LOAD;
    else if (win)                 pu_cnt <= pu_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !act) begin
      run_q   <= 1'b0;
      div_cnt <= '0;
      link_on <= 1'b0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      div_cnt <= '0;
      link_on <= 1'b1;
    end else if (div_cnt == DIV_LAST) begin
      div_cnt <= '0;
      link_on <= ~link_on;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  a_r1_active_blocks_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (link_active && wake) |=> !req_q);

  a_r2_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_active && wake) |=> req_q);

  a_r4_active_clears: assert property (@(posedge clk) disable iff (!rst_n)
    link_active |=> (!req_q && pu_cnt == '0));

  a_r5_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !link_active && !wake) |=> !req_q);

  a_r5_int_override: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && int_hold && !link_active) |=> req_q);

  a_r6_class_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !class_ok && !win) |=> !win);

  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pu_cnt <= PU_LOAD);

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !link_on);

  a_r7_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (act && run_q && div_cnt != DIV_LAST) |=> $stable(link_on));

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (act && run_q && div_cnt == DIV_LAST) |=> (link_on != $past(link_on)));

endmodule

// File: tb/linkon_wake_gen_bench.sv
`timescale 1ns/1ps
module linkon_wake_gen_bench;

  localparam int DH = 3;
  localparam int PU = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_status = 1'b0, link_ctrl = 1'b0, linkon_pkt = 1'b0;
  logic phy_int = 1'b0, phy_int_en = 1'b0, bus_reset = 1'b0, pwr_on = 1'b0;
  logic [2:0] pwr_class = 3'd0;
  logic link_on;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  linkon_wake_gen #(.DIV_HALF(DH), .PWRUP_CYCLES(PU)) u_linkon_wake_gen (
    .clk(clk), .rst_n(rst_n), .link_status(link_status), .link_ctrl(link_ctrl),
    .linkon_pkt(linkon_pkt), .phy_int(phy_int), .phy_int_en(phy_int_en),
    .bus_reset(bus_reset), .pwr_class(pwr_class), .pwr_on(pwr_on), .link_on(link_on)
  );

  // {pre-armed, link_status, link_ctrl, pkt, int, int_en, bus_reset, expect running}
  localparam logic [7:0] VEC [13] = '{
    8'b0_00_0000_0,  // idle, nothing happens
    8'b0_00_1000_1,  // R2 both low
    8'b0_10_1000_1,  // R2 ctrl low
    8'b0_01_1000_1,  // R2 status low
    8'b0_11_1000_0,  // R1 active link ignores packet
    8'b0_00_0110_1,  // R3 enabled interrupt wakes
    8'b0_00_0100_0,  // R3 disabled interrupt ignored
    8'b1_00_0000_1,  // R4 keeps running
    8'b1_00_0001_0,  // R5 bus reset clears
    8'b1_00_0111_1,  // R5 interrupt override
    8'b1_00_0101_0,  // R5 interrupt without enable does not override
    8'b1_11_0000_0,  // R4 link active clears
    8'b0_00_1001_1   // R5 wake wins over bus reset
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic settle_active();
    link_status = 1'b1; link_ctrl = 1'b1; linkon_pkt = 1'b0; bus_reset = 1'b0;
    phy_int = 1'b0; phy_int_en = 1'b0; pwr_on = 1'b0; pwr_class = 3'd0;
    repeat (3) step();
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int j = 0; j < n; j++) begin
      step();
      highs += int'(link_on);
    end
  endtask

  task automatic window_run(input logic [2:0] cls, input int n, output int highs);
    settle_active();
    link_status = 1'b0; link_ctrl = 1'b0;
    pwr_class = cls; pwr_on = 1'b1;
    step();
    pwr_on = 1'b0;
    count_high(n, highs);
  endtask

  initial begin
    int highs;
    int mism;
    int rows;
    logic [7:0] v;
    repeat (3) step();
    chk("R8 output low in reset", int'(link_on), 0);
    rst_n = 1'b1;
    step();
    chk("R8 output low after reset", int'(link_on), 0);

    rows = 0;
    for (int i = 0; i < 13; i++) begin
      v = VEC[i];
      settle_active();
      if (v[7]) begin
        link_status = 1'b0; link_ctrl = 1'b0; linkon_pkt = 1'b1;
        step();
        linkon_pkt = 1'b0;
        step();
      end
      link_status = v[6]; link_ctrl = v[5]; linkon_pkt = v[4];
      phy_int = v[3]; phy_int_en = v[2]; bus_reset = v[1];
      step();
      linkon_pkt = 1'b0; bus_reset = 1'b0;
      step();
      count_high(7, highs);
      chk($sformatf("wake/clear vector %0d", i), int'(highs != 0), int'(v[0]));
      rows++;
    end

    // R7 waveform shape
    settle_active();
    link_status = 1'b0; link_ctrl = 1'b0; linkon_pkt = 1'b1;
    step();
    linkon_pkt = 1'b0;
    mism = 0;
    for (int j = 0; j < 4 * DH; j++) begin
      step();
      if (link_on != (((j / DH) % 2) == 0)) mism++;
    end
    chk("R7 square wave pattern mismatches", mism, 0);

    // R4 stops within two edges of link becoming active
    link_status = 1'b1; link_ctrl = 1'b1;
    step();
    count_high(8, highs);
    chk("R4 output stops after link active", highs, 0);

    // R6 power-up window
    window_run(3'd2, PU, highs);
    chk("R6 class 2 window high cycles", highs, 11);
    count_high(10, highs);
    chk("R6 window ends after PWRUP_CYCLES", highs, 0);
    window_run(3'd4, PU, highs);
    chk("R6 class 4 window high cycles", highs, 11);
    window_run(3'd5, 25, highs);
    chk("R6 class 5 skips window", highs, 0);
    window_run(3'd7, 25, highs);
    chk("R6 class 7 skips window", highs, 0);
    window_run(3'd0, 5, highs);
    link_status = 1'b1; link_ctrl = 1'b1;
    step();
    count_high(10, highs);
    chk("R6 window cut by link active", highs, 0);
    link_status = 1'b0; link_ctrl = 1'b0;
    count_high(10, highs);
    chk("R6 window does not resume", highs, 0);

    // R8 reset discards a running request
    settle_active();
    link_status = 1'b0; link_ctrl = 1'b0; linkon_pkt = 1'b1;
    step();
    linkon_pkt = 1'b0;
    step();
    rst_n = 1'b0;
    step();
    chk("R8 reset forces output low", int'(link_on), 0);
    rst_n = 1'b1;
    count_high(8, highs);
    chk("R8 request discarded by reset", highs, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule